// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sits beside the CPU of a small 8-bit controller and sequences its two power-saving modes. A wait request from the CPU gates off the CPU clock and leaves the bus clock running, so peripherals keep working and can wake the system. A stop request gates off both clocks and clears the stabilization counter. Each mode ends on a reset request, a break request or an enabled interrupt request. The block then drives the clock enables, the stacking strobe and the reset-hold signal that the core, the clock generator and the interrupt logic use.

Stop exit waits for the clock to settle before stacking may begin. The wait is 4096 fast-clock cycles for crystal-type sources, or 32 cycles when the short-recovery configuration bit is set. A reset taken during wait holds the core in reset for 32 cycles. A break seen in either mode sets a sticky status bit that software clears. All control and status pins are plain levels or single-cycle pulses. No streaming data passes through the block, so there is no valid/ready handshake.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset, both clock enables are 1, and wake_cause_o, brk_flag_o, stack_start_o, rec_done_o, reset_hold_o and rec_count_o are all 0.
- R2: A wait request taken in run state gives cpu_clk_en_o=0 and bus_clk_en_o=1 from the next cycle. A stop request overrides a wait request that arrives in the same cycle.
- R3: In wait, any bit set in both irq_req_i and irq_en_i ends the mode. stack_start_o then pulses high for exactly one cycle, in the cycle after the request was seen. Interrupt bits whose enable is 0 do not wake the block.
- R4: A stop request gives cpu_clk_en_o=0, bus_clk_en_o=0 and rec_count_o=0 from the next cycle.
- R5: A break or interrupt wake from stop starts a recovery count. The count lasts L cycles, where L is 4096 when short_rec_i=0 and 32 when short_rec_i=1, sampled at the wake. Both clocks stay off during the count, and rec_count_o steps 0..L-1. In the next cycle rec_done_o and stack_start_o pulse together and both clock enables return to 1.
- R6: After recovery, rec_count_o holds its terminal value until the next stop entry or reset recovery.
- R7: A reset request in wait drives reset_hold_o high for 32 cycles. A reset request in stop holds it for the selected L of R5. When the hold is released, rec_done_o pulses and stack_start_o stays 0.
- R8: When causes arrive together, reset wins over break, and break wins over interrupt. wake_cause_o is one-hot: bit 2 is reset, bit 1 is break, bit 0 is interrupt. It holds the winning cause until the next mode entry, which clears it to 0.
- R9: A break request seen while in wait or stop sets brk_flag_o. A break request in run state leaves it unchanged. The flag stays set until brk_flag_clr_i, and a set in the same cycle as a clear wins.
- R10: wdog_en_o equals the inverse of wdog_dis_i in every state, including wait and stop.
- R11: Wait and stop requests that arrive during a recovery count or reset hold are ignored. The block returns to run state and stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_x4_i | input | 1 | Fast (x4) clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wait_req_i | input | 1 | Wait mode request from CPU |
| stop_req_i | input | 1 | Stop mode request from CPU |
| irq_req_i | input | N_IRQ | Module interrupt requests |
| irq_en_i | input | N_IRQ | Per-source interrupt enables |
| reset_req_i | input | 1 | Reset request (wake cause) |
| break_req_i | input | 1 | Break request (wake cause) |
| short_rec_i | input | 1 | 1 selects short stop recovery |
| wdog_dis_i | input | 1 | Watchdog disable configuration bit |
| brk_flag_clr_i | input | 1 | Bus write of 0 to the break status bit |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| bus_clk_en_o | output | 1 | x2/x4 bus clock enable |
| wdog_en_o | output | 1 | Watchdog enable |
| rec_count_o | output | CNT_W | Recovery counter value |
| rec_done_o | output | 1 | Recovery finished pulse |
| stack_start_o | output | 1 | Start interrupt stacking pulse |
| reset_hold_o | output | 1 | Core held in reset |
| wake_cause_o | output | 3 | One-hot wake cause |
| brk_flag_o | output | 1 | Break stop/wait status bit |

## Verification
Two functions can fall in the same cycle. The first is the arrival of two or three wake causes together, which the priority arbiter must resolve. The second is a break setting the status bit while software clears it. The bench randomly asserts reset, break and masked or unmasked interrupts together in one wake cycle, in both modes. It checks the one-hot cause, which recovery path is taken (reset hold, immediate stacking, or the counted stop delay) and the break bit against values computed from the priority rule. A directed case raises a break and the clear strobe in one cycle and expects the bit to stay set.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_WAIT = 3'd1,
    ST_STOP = 3'd2,
    ST_SREC = 3'd3,
    ST_RREC = 3'd4
  } lpm_state_t;

  localparam int CAUSE_W = 3;
  localparam logic [CAUSE_W-1:0] CAUSE_IRQ = 3'b001;
  localparam logic [CAUSE_W-1:0] CAUSE_BRK = 3'b010;
  localparam logic [CAUSE_W-1:0] CAUSE_RST = 3'b100;
  localparam logic [CAUSE_W-1:0] CAUSE_NONE = 3'b000;
endpackage

// File: rtl/lpm_wake_arb.sv
module lpm_wake_arb #(
  parameter int N_IRQ = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reset_req_i,
  input  logic             break_req_i,
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  output logic [lpm_pkg::CAUSE_W-1:0] cause_o,
  output logic             any_o
);
  import lpm_pkg::*;

  logic [N_IRQ-1:0] irq_live;
  logic             irq_any;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_mask
    assign irq_live[g] = irq_req_i[g] & irq_en_i[g];
  end
  assign irq_any = |irq_live;

  always_comb begin
    if (reset_req_i)      cause_o = CAUSE_RST;
    else if (break_req_i) cause_o = CAUSE_BRK;
    else if (irq_any)     cause_o = CAUSE_IRQ;
    else                  cause_o = CAUSE_NONE;
  end
  assign any_o = reset_req_i | break_req_i | irq_any;

  // R8: winner is one-hot, and a reset always wins
  a_r8_onehot_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cause_o) && (any_o == (cause_o != CAUSE_NONE)));
  a_r8_reset_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_i |-> cause_o[2]);
endmodule

// File: rtl/lpm_rec_counter.sv
module lpm_rec_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] term_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  assign last_o = en_i && (cnt_q == term_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (en_i && !last_o)   cnt_q <= cnt_q + 1'b1;
  end

  // R6: value frozen while not counting
  a_r6_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_o));
  // R5: count never passes the terminal value
  a_r5_within_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_o <= term_i));
endmodule

// File: rtl/lpm_brk_status.sv
module lpm_brk_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  // R9: set wins over clear, and the bit is sticky
  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer #(
  parameter int N_IRQ     = 8,
  parameter int CNT_W     = 12,
  parameter int LONG_REC  = 4096,
  parameter int SHORT_REC = 32,
  parameter int RST_HOLD  = 32
) (
  input  logic             clk_x4_i,
  input  logic             rst_ni,
  input  logic             wait_req_i,
  input  logic             stop_req_i,
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             reset_req_i,
  input  logic             break_req_i,
  input  logic             short_rec_i,
  input  logic             wdog_dis_i,
  input  logic             brk_flag_clr_i,
  output logic             cpu_clk_en_o,
  output logic             bus_clk_en_o,
  output logic             wdog_en_o,
  output logic [CNT_W-1:0] rec_count_o,
  output logic             rec_done_o,
  output logic             stack_start_o,
  output logic             reset_hold_o,
  output logic [2:0]       wake_cause_o,
  output logic             brk_flag_o
);
  import lpm_pkg::*;

  localparam logic [CNT_W-1:0] LONG_T  = CNT_W'(LONG_REC - 1);
  localparam logic [CNT_W-1:0] SHORT_T = CNT_W'(SHORT_REC - 1);
  localparam logic [CNT_W-1:0] HOLD_T  = CNT_W'(RST_HOLD - 1);

  lpm_state_t       st_q, st_d;
  logic [CNT_W-1:0] term_q, term_d, sel_term;
  logic [2:0]       cause_q, cause_d, win_cause;
  logic             stack_q, stack_d, done_q, done_d;
  logic             win_any, cnt_clr, cnt_en, cnt_last, brk_set;

  lpm_wake_arb #(.N_IRQ(N_IRQ)) u_arb (
    .clk_i       (clk_x4_i),
    .rst_ni      (rst_ni),
    .reset_req_i (reset_req_i),
    .break_req_i (break_req_i),
    .irq_req_i   (irq_req_i),
    .irq_en_i    (irq_en_i),
    .cause_o     (win_cause),
    .any_o       (win_any)
  );

  assign cnt_en = (st_q == ST_SREC) || (st_q == ST_RREC);

  lpm_rec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_x4_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .en_i   (cnt_en),
    .term_i (term_q),
    .cnt_o  (rec_count_o),
    .last_o (cnt_last)
  );

  assign brk_set = break_req_i && ((st_q == ST_WAIT) || (st_q == ST_STOP));

  lpm_brk_status u_brk (
    .clk_i  (clk_x4_i),
    .rst_ni (rst_ni),
    .set_i  (brk_set),
    .clr_i  (brk_flag_clr_i),
    .flag_o (brk_flag_o)
  );

  assign sel_term = short_rec_i ? SHORT_T : LONG_T;

  always_comb begin
    st_d    = st_q;
    term_d  = term_q;
    cause_d = cause_q;
    stack_d = 1'b0;
    done_d  = 1'b0;
    cnt_clr = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (stop_req_i) begin
          st_d    = ST_STOP;
          cnt_clr = 1'b1;
          cause_d = CAUSE_NONE;
        end else if (wait_req_i) begin
          st_d    = ST_WAIT;
          cause_d = CAUSE_NONE;
        end
      end
      ST_WAIT: begin
        if (win_any) begin
          cause_d = win_cause;
          if (win_cause == CAUSE_RST) begin
            st_d    = ST_RREC;
            term_d  = HOLD_T;
            cnt_clr = 1'b1;
          end else begin
            st_d    = ST_RUN;
            stack_d = 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (win_any) begin
          cause_d = win_cause;
          term_d  = sel_term;
          st_d    = (win_cause == CAUSE_RST) ? ST_RREC : ST_SREC;
        end
      end
      ST_SREC: begin
        if (cnt_last) begin
          st_d    = ST_RUN;
          stack_d = 1'b1;
          done_d  = 1'b1;
        end
      end
      ST_RREC: begin
        if (cnt_last) begin
          st_d   = ST_RUN;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_x4_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_RUN;
      term_q  <= SHORT_T;
      cause_q <= CAUSE_NONE;
      stack_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      term_q  <= term_d;
      cause_q <= cause_d;
      stack_q <= stack_d;
      done_q  <= done_d;
    end
  end

  assign cpu_clk_en_o  = (st_q == ST_RUN) || (st_q == ST_RREC);
  assign bus_clk_en_o  = (st_q == ST_RUN) || (st_q == ST_WAIT) || (st_q == ST_RREC);
  assign reset_hold_o  = (st_q == ST_RREC);
  assign stack_start_o = stack_q;
  assign rec_done_o    = done_q;
  assign wake_cause_o  = cause_q;
  assign wdog_en_o     = ~wdog_dis_i;

  // R3: enabled interrupt in wait stacks on the next cycle
  a_r3_wait_irq_stacks: assert property (@(posedge clk_x4_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && win_cause == CAUSE_IRQ) |=> (stack_start_o && cpu_clk_en_o));
  // R3: the stacking strobe is a single-cycle pulse
  a_r3_stack_pulse: assert property (@(posedge clk_x4_i) disable iff (!rst_ni)
    stack_start_o |=> !stack_start_o);
  // R4: stop entry clears the counter and halts the bus clock
  a_r4_stop_entry: assert property (@(posedge clk_x4_i) disable iff (!rst_ni)
    (st_q == ST_RUN && stop_req_i) |=> (rec_count_o == '0 && !bus_clk_en_o && !cpu_clk_en_o));
  // R5: recovery done comes with running clocks
  a_r5_done_clocks: assert property (@(posedge clk_x4_i) disable iff (!rst_ni)
    rec_done_o |-> (bus_clk_en_o && cpu_clk_en_o && !reset_hold_o));
  // R7: no stacking while reset is held
  a_r7_no_stack_in_hold: assert property (@(posedge clk_x4_i) disable iff (!rst_ni)
    reset_hold_o |-> !stack_start_o);
  // R8: cause output is one-hot or empty
  a_r8_cause_onehot: assert property (@(posedge clk_x4_i) disable iff (!rst_ni)
    $onehot0(wake_cause_o));
  // R10: watchdog enable follows its disable bit
  a_r10_wdog: assert property (@(posedge clk_x4_i) disable iff (!rst_ni)
    wdog_en_o != wdog_dis_i);
  // R11: requests during recovery do not start a mode
  a_r11_ignore_in_rec: assert property (@(posedge clk_x4_i) disable iff (!rst_ni)
    (cnt_en && !cnt_last) |=> cnt_en);
endmodule

// File: tb/lpm_sequencer_tb_top.sv
module lpm_sequencer_tb_top;
  localparam int NI = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wait_req, stop_req, reset_req, break_req, short_rec, wdog_dis, brk_clr;
  logic [NI-1:0] irq_req, irq_en;
  logic          cpu_en, bus_en, wdog_en, done, stack, hold, flag;
  logic [11:0]   cnt;
  logic [2:0]    cause;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lpm_sequencer #(.N_IRQ(NI)) dut_i (
    .clk_x4_i       (clk),
    .rst_ni         (rst_n),
    .wait_req_i     (wait_req),
    .stop_req_i     (stop_req),
    .irq_req_i      (irq_req),
    .irq_en_i       (irq_en),
    .reset_req_i    (reset_req),
    .break_req_i    (break_req),
    .short_rec_i    (short_rec),
    .wdog_dis_i     (wdog_dis),
    .brk_flag_clr_i (brk_clr),
    .cpu_clk_en_o   (cpu_en),
    .bus_clk_en_o   (bus_en),
    .wdog_en_o      (wdog_en),
    .rec_count_o    (cnt),
    .rec_done_o     (done),
    .stack_start_o  (stack),
    .reset_hold_o   (hold),
    .wake_cause_o   (cause),
    .brk_flag_o     (flag)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_cause(bit r, bit b, bit i);
    if (r) return 4;
    if (b) return 2;
    if (i) return 1;
    return 0;
  endfunction

  function automatic int rec_len(bit is_stop, bit sh);
    if (!is_stop) return 32;
    return sh ? 32 : 4096;
  endfunction

  // enter a mode, wake it with the given mix of causes, and check the recovery path
  task automatic run_case(bit is_stop, bit r, bit b, bit ien, bit sh, bit inject);
    int L;
    int ec;
    logic [NI-1:0] v;
    brk_clr = 1'b1; step(); brk_clr = 1'b0;
    short_rec = sh;
    wdog_dis = 1'($urandom % 2);
    if (is_stop) stop_req = 1'b1; else wait_req = 1'b1;
    step();
    stop_req = 1'b0; wait_req = 1'b0;
    chk("R2/R4 cpu clock off", int'(cpu_en), 0);
    chk("R2/R4 bus clock", int'(bus_en), is_stop ? 0 : 1);
    chk("R8 cause cleared on entry", int'(cause), 0);
    chk("R10 watchdog enable", int'(wdog_en), wdog_dis ? 0 : 1);
    if (is_stop) chk("R4 counter cleared", int'(cnt), 0);
    v = NI'($urandom % 255 + 1);
    irq_req = v;
    irq_en  = ien ? v : ~v;
    reset_req = r; break_req = b;
    step();
    irq_req = '0; irq_en = '0; reset_req = 1'b0; break_req = 1'b0;
    ec = exp_cause(r, b, ien);
    L  = rec_len(is_stop, sh);
    if (r) begin
      chk("R7 hold asserted", int'(hold), 1);
      repeat (L - 1) step();
      chk("R7 hold still asserted", int'(hold), 1);
      chk("R7 no done yet", int'(done), 0);
      step();
      chk("R7 hold released", int'(hold), 0);
      chk("R7 done pulse", int'(done), 1);
      chk("R7 no stacking", int'(stack), 0);
    end else if (!is_stop) begin
      chk("R3 stack strobe", int'(stack), 1);
      chk("R3 cpu clock back", int'(cpu_en), 1);
      step();
      chk("R3 strobe one cycle", int'(stack), 0);
    end else begin
      if (inject) begin
        wait_req = 1'b1; stop_req = 1'b1;
        repeat (3) step();
        wait_req = 1'b0; stop_req = 1'b0;
        repeat (L - 4) step();
      end else begin
        repeat (L - 1) step();
      end
      chk("R5 bus clock off during count", int'(bus_en), 0);
      chk("R5 count at terminal", int'(cnt), L - 1);
      chk("R5 no early stacking", int'(stack), 0);
      step();
      chk("R5 done pulse", int'(done), 1);
      chk("R5 stack with done", int'(stack), 1);
      chk("R5 bus clock back", int'(bus_en), 1);
      step();
      chk("R6 counter holds", int'(cnt), L - 1);
      chk("R5 done one cycle", int'(done), 0);
      if (inject) chk("R11 stays in run", int'(cpu_en), 1);
    end
    chk("R8 wake cause", int'(cause), ec);
    chk("R9 break flag", int'(flag), int'(b));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    {wait_req, stop_req, reset_req, break_req, short_rec, wdog_dis, brk_clr} = '0;
    irq_req = '0; irq_en = '0;
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R1 cpu clock", int'(cpu_en), 1);
    chk("R1 bus clock", int'(bus_en), 1);
    chk("R1 cause", int'(cause), 0);
    chk("R1 flag", int'(flag), 0);
    chk("R1 stack/done/hold", int'({stack, done, hold}), 0);
    chk("R1 count", int'(cnt), 0);

    // R3: masked interrupt leaves wait alone
    short_rec = 1'b1;
    wait_req = 1'b1; step(); wait_req = 1'b0;
    irq_req = 8'h0F; irq_en = 8'hF0;
    repeat (3) step();
    chk("R3 masked irq ignored", int'(cpu_en), 0);
    irq_req = '0; irq_en = '0;
    // R9: set and clear in one cycle, set wins
    break_req = 1'b1; brk_clr = 1'b1; step();
    break_req = 1'b0; brk_clr = 1'b0;
    chk("R9 set wins over clear", int'(flag), 1);
    step();
    brk_clr = 1'b1; step(); brk_clr = 1'b0;
    chk("R9 cleared by write", int'(flag), 0);
    // R9: break in run does not set the bit
    break_req = 1'b1; step(); break_req = 1'b0;
    chk("R9 no set in run", int'(flag), 0);

    // R2: stop beats wait
    wait_req = 1'b1; stop_req = 1'b1; step();
    wait_req = 1'b0; stop_req = 1'b0;
    chk("R2 stop overrides wait", int'(bus_en), 0);
    irq_req = 8'h01; irq_en = 8'h01; step();
    irq_req = '0; irq_en = '0;
    repeat (32) step();
    chk("R2 back in run", int'(cpu_en), 1);

    // directed long recoveries and ignored requests
    run_case(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // R5 long
    run_case(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R7 stop reset long
    run_case(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1); // R11 requests in recovery
    run_case(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); // R8 all three together

    for (int k = 0; k < 40; k++) begin
      bit s, r, b, i;
      s = 1'($urandom % 2);
      r = 1'($urandom % 2);
      b = 1'($urandom % 2);
      i = 1'($urandom % 2);
      if (!r && !b && !i) i = 1'b1;
      run_case(s, r, b, i, 1'b1, 1'($urandom % 2));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule